// File: doc/BRIEF.md
# Filtered Quadrature Encoder Counter

This block turns the four raw lines of an incremental encoder channel (phase A, phase B, index and an index gate) into a signed position count. Each line passes through a digital noise filter. The filter accepts a new level only after that level has been stable for a run of sample clocks. The run is 15 samples by default, or 3 when fast filtering is selected. The filtered phases are decoded either as a quadrature pair or as a step line plus a direction line.

Two counts are kept. The working count can be forced to zero by a level-sensitive clear input. It can also be zeroed by an index event once the index logic has been armed. An arm pulse sets the armed flag, and the first qualifying index edge zeroes the count and drops the flag in the same clock. The edge polarity is selectable, and the index can be qualified by the level of the gate line. The raw count follows every decoded move and is never cleared. A strobe from an external timer, when enabled, copies the working count into a holding register for later readout.

Top module: `qenc_counter`

## Requirements
- R1: With `filt_fast` low, which is the setting used when it is tied low after reset, a new input level is accepted only after it has been sampled on 15 consecutive clocks. A pulse of 14 samples leaves the count unchanged. An accepted phase change shows on `count` at the 17th rising edge after the input changes.
- R2: With `filt_fast` high, a level held for 3 samples is accepted, and a 2-sample pulse is rejected.
- R3: In quadrature mode (`step_mode` low), the filtered pair {A,B} stepping through the sequence 00, 10, 11, 01 and back to 00 adds one per transition. The reverse order subtracts one per transition.
- R4: In quadrature mode, a transition where A and B change together leaves both counts unchanged.
- R5: In step mode (`step_mode` high), each filtered rising edge of A adds one when B is 0 and subtracts one when B is 1. Falling edges of A and changes of B do not count.
- R6: While `count_clear` is high, `count` reads zero from the next clock on, and `raw_count` keeps following motion.
- R7: A one-clock pulse on `idx_arm` sets `idx_armed`. The next qualifying index edge zeroes `count` and clears `idx_armed` on the same clock, and `raw_count` is left unchanged. When the logic is not armed, index edges have no effect on `count`.
- R8: An index edge qualifies on a filtered rising edge of the index line when `idx_rise_sel` is 1, and on a falling edge when it is 0.
- R9: With `gate_en` high, an index edge qualifies only when the filtered gate line is high (if `gate_low` is 0) or low (if `gate_low` is 1).
- R10: On a clock with both `latch_strobe` and `latch_en` high, `latched_count` takes the value `count` held before that edge. When `latch_en` is low, a strobe leaves `latched_count` unchanged.
- R11: Both counts are two's-complement values of CNT_W bits that wrap modulo 2^CNT_W, so the largest positive value plus one gives the most negative value, and zero minus one gives all ones.
- R12: After reset, `count`, `raw_count` and `latched_count` are zero and `idx_armed` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_a | input | 1 | Phase A, or step line in step mode |
| enc_b | input | 1 | Phase B, or direction line in step mode |
| enc_idx | input | 1 | Index line |
| enc_idx_gate | input | 1 | Index gate line |
| filt_fast | input | 1 | 1 selects the 3-sample filter, 0 selects the 15-sample filter |
| step_mode | input | 1 | 1 selects step/direction decoding, 0 selects quadrature |
| idx_rise_sel | input | 1 | 1 triggers on the rising index edge, 0 on the falling edge |
| gate_en | input | 1 | Enables index qualification by the gate line |
| gate_low | input | 1 | 1 requires the gate line low, 0 requires it high |
| count_clear | input | 1 | Level clear of the working count |
| idx_arm | input | 1 | Pulse that arms index zeroing |
| idx_armed | output | 1 | Index zeroing is armed |
| latch_strobe | input | 1 | Timer strobe |
| latch_en | input | 1 | Allows the strobe to capture the count |
| count | output | CNT_W | Working count, two's complement |
| raw_count | output | CNT_W | Count that is never cleared, two's complement |
| latched_count | output | CNT_W | Count captured by the strobe |

## Verification
A filter run counter that drifts shows up as a glitch that gets through, or as a valid edge that reaches `count` one clock early or late. The bench measures that latency to the exact clock. A wrong stored phase in the decoder shows up within one transition as a miscount or a wrong sign in both `count` and `raw_count`. A stuck or lost armed flag appears on `idx_armed` at once, and as a missing or spurious zeroing on the next index edge. Because every check compares against a running arithmetic model, one wrong count persists in all later comparisons.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
    typedef enum logic [1:0] {
        MOVE_NONE = 2'b00,
        MOVE_UP   = 2'b01,
        MOVE_DOWN = 2'b10
    } move_t;
endpackage

// File: rtl/qenc_filter.sv
module qenc_filter #(
    parameter int LONG_N  = 15,
    parameter int SHORT_N = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    input  logic fast,
    output logic sig_out
);
    localparam int CW = $clog2(LONG_N + 1);
    localparam logic [CW-1:0] LONG_LIM  = CW'(LONG_N - 1);
    localparam logic [CW-1:0] SHORT_LIM = CW'(SHORT_N - 1);

    typedef struct packed {
        logic          smp;
        logic [CW-1:0] run;
        logic          out;
    } filt_st_t;

    filt_st_t st_d, st_q;
    logic [CW-1:0] lim;

    always_comb begin
        st_d     = st_q;
        lim      = fast ? SHORT_LIM : LONG_LIM;
        st_d.smp = sig_in;
        if (st_q.smp != st_q.out) begin
            if (st_q.run == lim) begin
                st_d.out = st_q.smp;
                st_d.run = '0;
            end else begin
                st_d.run = st_q.run + 1'b1;
            end
        end else begin
            st_d.run = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sig_out = st_q.out;

    // R1
    accept_matches_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.out != $past(st_q.out)) |-> ($past(st_q.smp) == st_q.out));
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
    import qenc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ph_a,
    input  logic  ph_b,
    input  logic  step_mode,
    output move_t move
);
    typedef struct packed {
        logic a;
        logic b;
    } dec_st_t;

    dec_st_t st_d, st_q;
    logic [1:0] pos_now, pos_old, pos_diff;

    always_comb begin
        st_d.a   = ph_a;
        st_d.b   = ph_b;
        pos_now  = {ph_b, ph_a ^ ph_b};
        pos_old  = {st_q.b, st_q.a ^ st_q.b};
        pos_diff = pos_now - pos_old;
        move     = MOVE_NONE;
        if (step_mode) begin
            if (ph_a && !st_q.a) move = ph_b ? MOVE_DOWN : MOVE_UP;
        end else begin
            case (pos_diff)
                2'd1:    move = MOVE_UP;
                2'd3:    move = MOVE_DOWN;
                default: move = MOVE_NONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    double_change_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_mode && ph_a != st_q.a && ph_b != st_q.b) |-> (move == MOVE_NONE));

    // R5
    step_only_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_mode && !(ph_a && !st_q.a)) |-> (move == MOVE_NONE));
endmodule

// File: rtl/qenc_index.sv
module qenc_index (
    input  logic clk,
    input  logic rst_n,
    input  logic idx,
    input  logic gate,
    input  logic rise_sel,
    input  logic gate_en,
    input  logic gate_low,
    output logic fire
);
    typedef struct packed {
        logic idx;
    } idx_st_t;

    idx_st_t st_d, st_q;
    logic edge_seen, gate_ok;

    always_comb begin
        st_d.idx  = idx;
        edge_seen = rise_sel ? (idx && !st_q.idx) : (!idx && st_q.idx);
        gate_ok   = !gate_en || (gate != gate_low);
        fire      = edge_seen && gate_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9
    gate_blocks_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && gate == gate_low) |-> !fire);

    // R8
    fire_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (idx != st_q.idx));
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
    import qenc_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int LONG_N  = 15,
    parameter int SHORT_N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             enc_idx,
    input  logic             enc_idx_gate,
    input  logic             filt_fast,
    input  logic             step_mode,
    input  logic             idx_rise_sel,
    input  logic             gate_en,
    input  logic             gate_low,
    input  logic             count_clear,
    input  logic             idx_arm,
    output logic             idx_armed,
    input  logic             latch_strobe,
    input  logic             latch_en,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] raw_count,
    output logic [CNT_W-1:0] latched_count
);
    localparam int NPIN = 4;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] MONE = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] raw;
        logic [CNT_W-1:0] held;
        logic             armed;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [NPIN-1:0] pin_raw, pin_flt;
    move_t           move;
    logic            fire;
    logic [CNT_W-1:0] inc;

    assign pin_raw = {enc_idx_gate, enc_idx, enc_b, enc_a};

    for (genvar g = 0; g < NPIN; g++) begin : g_filt
        qenc_filter #(.LONG_N(LONG_N), .SHORT_N(SHORT_N)) i_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig_in (pin_raw[g]),
            .fast   (filt_fast),
            .sig_out(pin_flt[g])
        );
    end

    qenc_decode i_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .ph_a     (pin_flt[0]),
        .ph_b     (pin_flt[1]),
        .step_mode(step_mode),
        .move     (move)
    );

    qenc_index i_idx (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (pin_flt[2]),
        .gate    (pin_flt[3]),
        .rise_sel(idx_rise_sel),
        .gate_en (gate_en),
        .gate_low(gate_low),
        .fire    (fire)
    );

    always_comb begin
        st_d = st_q;
        case (move)
            MOVE_UP:   inc = ONE;
            MOVE_DOWN: inc = MONE;
            default:   inc = '0;
        endcase
        st_d.raw = st_q.raw + inc;
        if (count_clear)              st_d.cnt = '0;
        else if (st_q.armed && fire)  st_d.cnt = '0;
        else                          st_d.cnt = st_q.cnt + inc;
        st_d.armed = (st_q.armed && !fire) || idx_arm;
        if (latch_strobe && latch_en) st_d.held = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count         = st_q.cnt;
    assign raw_count     = st_q.raw;
    assign latched_count = st_q.held;
    assign idx_armed     = st_q.armed;

    // R6
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_clear |=> (count == '0));

    // R7
    disarm_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idx_armed) |-> (count == '0));

    // R11
    raw_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 ((raw_count - $past(raw_count)) == '0 || (raw_count - $past(raw_count)) == ONE
             || (raw_count - $past(raw_count)) == MONE));

    // R10
    latch_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_strobe && latch_en) |=> (latched_count == $past(count)));
endmodule

// File: tb/test_qenc_counter.sv
module test_qenc_counter;
    localparam int CLK_T = 10;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a = 0, b = 0, idx = 0, gt = 0;
    logic fast = 0, smode = 0, rsel = 1, gen = 0, glow = 0;
    logic clr = 0, arm = 0, stb = 0, len = 0;
    logic armed;
    logic [W-1:0] cnt, raw, held;
    logic [W-1:0] exp_cnt = '0, exp_raw = '0, exp_held = '0;
    int p = 0;
    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_T/2) clk = ~clk;

    qenc_counter #(.CNT_W(W)) i_qenc_counter (
        .clk(clk), .rst_n(rst_n), .enc_a(a), .enc_b(b), .enc_idx(idx),
        .enc_idx_gate(gt), .filt_fast(fast), .step_mode(smode),
        .idx_rise_sel(rsel), .gate_en(gen), .gate_low(glow),
        .count_clear(clr), .idx_arm(arm), .idx_armed(armed),
        .latch_strobe(stb), .latch_en(len), .count(cnt),
        .raw_count(raw), .latched_count(held)
    );

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        wt(fast ? 8 : 20);
    endtask

    task automatic set_ph(int np);
        logic [1:0] ph;
        ph = 2'(np);
        a = ph[1] ^ ph[0];
        b = ph[1];
    endtask

    task automatic qstep(int dir);
        p = p + dir;
        set_ph(p);
        settle();
        exp_raw = exp_raw + W'(dir);
        if (!clr) exp_cnt = exp_cnt + W'(dir);
    endtask

    task automatic pulse_idx();
        idx = 1; settle();
        idx = 0; settle();
    endtask

    task automatic do_arm();
        arm = 1; wt(1); arm = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        wt(3);
        rst_n = 1;
        wt(1);
        // R12
        chk("R12 count", cnt, 0);
        chk("R12 raw", raw, 0);
        chk("R12 latched", held, 0);
        chk("R12 armed", W'(armed), 0);

        // R1 exact latency with long filter
        p = 1; set_ph(p);
        wt(16);
        chk("R1 before accept", cnt, 0);
        wt(1);
        chk("R1 at accept", cnt, 1);
        exp_cnt = 1; exp_raw = 1;
        wt(5);
        // R1 14-sample glitch rejected
        b = 1; wt(14); b = 0; wt(25);
        chk("R1 glitch14", cnt, exp_cnt);
        // R1 15-sample pulse accepted, then reverts
        b = 1; wt(15); b = 0; wt(2);
        chk("R1 pulse15", cnt, 2);
        wt(25);
        chk("R1 pulse15 back", cnt, 1);
        chk("R1 raw back", raw, 1);

        // R2 short filter
        fast = 1; wt(2);
        b = 1; wt(2); b = 0; wt(10);
        chk("R2 glitch2", cnt, 1);
        b = 1; wt(3); b = 0; wt(2);
        chk("R2 pulse3", cnt, 2);
        wt(10);
        chk("R2 pulse3 back", cnt, 1);

        // R3 sweeps
        for (int i = 0; i < 12; i++) begin
            qstep(1);
            chk("R3 up", cnt, exp_cnt);
        end
        for (int i = 0; i < 20; i++) begin
            qstep(-1);
            chk("R3 down", cnt, exp_cnt);
        end
        // R11 below zero wraps to all ones
        chk("R11 negative", cnt, exp_cnt);
        chk("R3 raw", raw, exp_raw);

        // R4 illegal double change
        p = p + 2; set_ph(p); settle();
        chk("R4 double change", cnt, exp_cnt);
        chk("R4 raw double", raw, exp_raw);
        qstep(1);
        chk("R4 resume", cnt, exp_cnt);

        // R11 positive wrap
        for (int i = 0; i < 260 && exp_cnt != 8'h7F; i++) qstep(1);
        chk("R11 max", cnt, 8'h7F);
        qstep(1);
        chk("R11 wrap", cnt, 8'h80);

        // R6 clear level
        clr = 1; wt(1);
        exp_cnt = 0;
        chk("R6 cleared", cnt, 0);
        qstep(1); qstep(1); qstep(1);
        chk("R6 held zero", cnt, 0);
        chk("R6 raw moves", raw, exp_raw);
        clr = 0; wt(1);
        qstep(1);
        chk("R6 released", cnt, 1);

        // R7 not armed: index ignored
        qstep(1); qstep(1);
        rsel = 1;
        pulse_idx();
        chk("R7 unarmed", cnt, exp_cnt);
        do_arm();
        chk("R7 armed set", W'(armed), 1);
        idx = 1; settle();
        exp_cnt = 0;
        chk("R7 zeroed", cnt, 0);
        chk("R7 disarmed", W'(armed), 0);
        chk("R7 raw kept", raw, exp_raw);
        idx = 0; settle();
        qstep(1); qstep(1);
        idx = 1; settle(); idx = 0; settle();
        chk("R7 one shot", cnt, exp_cnt);

        // R8 falling edge select
        rsel = 0;
        do_arm();
        idx = 1; settle();
        chk("R8 rise ignored", cnt, exp_cnt);
        chk("R8 still armed", W'(armed), 1);
        idx = 0; settle();
        exp_cnt = 0;
        chk("R8 fall fires", cnt, 0);
        chk("R8 disarmed", W'(armed), 0);

        // R9 gate high required
        rsel = 1; gen = 1; glow = 0; gt = 0; settle();
        qstep(1); qstep(1); qstep(1);
        do_arm();
        pulse_idx();
        chk("R9 gate low blocks", cnt, exp_cnt);
        chk("R9 still armed", W'(armed), 1);
        gt = 1; settle();
        idx = 1; settle();
        exp_cnt = 0;
        chk("R9 gate high fires", cnt, 0);
        idx = 0; settle();
        // R9 gate low required
        glow = 1;
        qstep(1); qstep(1);
        do_arm();
        pulse_idx();
        chk("R9 inverted blocks", cnt, exp_cnt);
        gt = 0; settle();
        idx = 1; settle();
        exp_cnt = 0;
        chk("R9 inverted fires", cnt, 0);
        idx = 0; settle();
        gen = 0;

        // R10 latch
        qstep(1); qstep(1); qstep(1); qstep(1);
        stb = 1; wt(1); stb = 0; wt(1);
        chk("R10 no enable", held, exp_held);
        len = 1; stb = 1; wt(1); stb = 0; len = 0; wt(1);
        exp_held = exp_cnt;
        chk("R10 captured", held, exp_held);
        qstep(1);
        chk("R10 holds", held, exp_held);

        // R5 step/dir: return to phase 00 first
        while (2'(p) != 2'd0) qstep(1);
        smode = 1; wt(2);
        a = 1; settle(); exp_cnt++; exp_raw++;
        chk("R5 up", cnt, exp_cnt);
        a = 0; settle();
        chk("R5 fall ignored", cnt, exp_cnt);
        b = 1; settle();
        chk("R5 dir change ignored", cnt, exp_cnt);
        a = 1; settle(); exp_cnt--; exp_raw--;
        chk("R5 down", cnt, exp_cnt);
        chk("R5 raw", raw, exp_raw);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule